// File: doc/BRIEF.md
# Dual-Comparator Timer Compare Output

This block is an up-counting timer with two compare values. One is a period value (P) and one is a match value (A). It drives a single output pin and keeps two sticky event flags, one for each comparator. Software turns the timer on with an enable bit and picks an operating mode from a 2-bit field. The block implements only the compare-match output mode, coded `00`. The other three codes are recognised, but they keep the counter parked at zero. The counter width is a parameter and may be 10 or 16 bits.

A clear-source select bit decides which comparator resets the counter. When it is low, the counter restarts after a P match and both comparators can raise their flags. When it is high, the counter restarts after an A match and the P flag stays quiet. A compare value of zero disables its comparator, so the counter wraps at full scale instead. Only an A match moves the output pin. The pin's response is chosen by a 2-bit action field. When the enable bit rises, the pin is preset to a chosen level.

Top module: `dual_cmp_timer`

## Requirements
- R1: When `enable` is 0, or `mode` is not `00` (compare-match output), `count` is 0 after the next clock edge and no flag is set.
- R2: With `clr_sel`=0 and `ccrp`≠0, the counter counts 0,1,…,`ccrp` and returns to 0 on the edge after `count`==`ccrp`. That edge sets `p_flag`. The edge after `count`==`ccra` (with `ccra`≠0) sets `a_flag`.
- R3: With `clr_sel`=0 and `ccrp`=0, the counter runs to 2^CNT_W−1 and wraps to 0, and `p_flag` is never set.
- R4: With `clr_sel`=1, the counter returns to 0 on the edge after `count`==`ccra`. `p_flag` is never set, even when `ccrp` is below `ccra`.
- R5: With `ccra`=0, no A match happens. The counter wraps at 2^CNT_W−1, `a_flag` is not set and the pin does not move.
- R6: On the edge after an A match, the pin follows `pin_act`: `00` leaves it unchanged, `01` drives it 0, `10` drives it 1, `11` toggles it.
- R7: A P match never changes `pin_out`.
- R8: On the edge where `enable` is first seen as 1 after being 0, `pin_out` takes the value of `init_lvl`.
- R9: Each flag stays set until its clear strobe (`a_flag_clr` / `p_flag_clr`) is 1 at an edge. If a set event and the strobe meet at the same edge, the flag stays set.
- R10: While the timer is not running, `pin_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Timer on |
| mode | input | 2 | Operating mode; `00` is compare-match output |
| pin_act | input | 2 | Pin response to an A match |
| init_lvl | input | 1 | Pin level loaded when enable rises |
| clr_sel | input | 1 | 0: P match clears counter; 1: A match clears counter |
| ccra | input | CNT_W | Match compare value A |
| ccrp | input | CNT_W | Period compare value P |
| a_flag_clr | input | 1 | Clear strobe for the A flag |
| p_flag_clr | input | 1 | Clear strobe for the P flag |
| count | output | CNT_W | Current counter value |
| a_flag | output | 1 | Sticky A-match flag |
| p_flag | output | 1 | Sticky P-match flag |
| pin_out | output | 1 | Compare output pin |

## Verification
The full-scale wrap is the hardest case to reach, because it only occurs when a compare value is zero. The stimulus forces it twice. The first run sets `ccrp` to zero with P clearing, and the second sets `ccra` to zero with A clearing. In each run the bench steps through the full 1024-count cycle and checks the value 1023 and then the wrap to zero. The set-wins-over-clear rule needs the strobe to land exactly on the cycle where the counter equals `ccrp`. The bench times that strobe from a known restart of the counter.

// File: rtl/dct_pkg.sv
package dct_pkg;

   typedef enum logic [1:0] {
      MODE_CMP_OUT = 2'b00,
      MODE_ALT_1   = 2'b01,
      MODE_ALT_2   = 2'b10,
      MODE_ALT_3   = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } pin_act_e;

   function automatic logic apply_action(input pin_act_e act, input logic cur);
      logic nxt;
      case (act)
         ACT_LOW:    nxt = 1'b0;
         ACT_HIGH:   nxt = 1'b1;
         ACT_TOGGLE: nxt = ~cur;
         default:    nxt = cur;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/dct_mode_dec.sv
module dct_mode_dec
   import dct_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic [1:0] mode,
   output logic       run,
   output logic       en_rise
);
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= enable;
   end

   assign run     = enable && (mode_e'(mode) == MODE_CMP_OUT);
   assign en_rise = enable && !en_q;
endmodule

// File: rtl/dct_cmp.sv
module dct_cmp #(
   parameter int W = 10
) (
   input  logic         armed,
   input  logic [W-1:0] value,
   input  logic [W-1:0] ref_val,
   output logic         hit
);
   logic ref_zero;
   assign ref_zero = (ref_val == '0);
   assign hit      = armed && !ref_zero && (value == ref_val);
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         restart,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '0;
      else if (!run)    count <= '0;
      else if (restart) count <= '0;
      else              count <= count + ONE;
   end
endmodule

// File: rtl/dct_flag.sv
module dct_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_stb,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)      flag <= 1'b0;
      else if (set_ev) flag <= 1'b1;
      else if (clr_stb) flag <= 1'b0;
   end
endmodule

// File: rtl/dct_pin.sv
module dct_pin
   import dct_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_rise,
   input  logic       init_lvl,
   input  logic       a_hit,
   input  logic [1:0] pin_act,
   output logic       pin_out
);
   always_ff @(posedge clk) begin
      if (!rst_n)       pin_out <= 1'b0;
      else if (en_rise) pin_out <= init_lvl;
      else if (a_hit)   pin_out <= apply_action(pin_act_e'(pin_act), pin_out);
   end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
   import dct_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [1:0]       mode,
   input  logic [1:0]       pin_act,
   input  logic             init_lvl,
   input  logic             clr_sel,
   input  logic [CNT_W-1:0] ccra,
   input  logic [CNT_W-1:0] ccrp,
   input  logic             a_flag_clr,
   input  logic             p_flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             a_flag,
   output logic             p_flag,
   output logic             pin_out
);
   localparam int NUM_CMP = 2;
   localparam int IDX_A   = 0;
   localparam int IDX_P   = 1;

   if (!(CNT_W == 10 || CNT_W == 16)) begin : g_bad_width
      $error("dual_cmp_timer: CNT_W must be 10 or 16");
   end

   logic run, en_rise, restart;
   logic [NUM_CMP-1:0]            hit;
   logic [NUM_CMP-1:0]            set_ev;
   logic [NUM_CMP-1:0]            clr_stb;
   logic [NUM_CMP-1:0]            flags;
   logic [NUM_CMP-1:0][CNT_W-1:0] refs;

   assign refs[IDX_A]    = ccra;
   assign refs[IDX_P]    = ccrp;
   assign clr_stb[IDX_A] = a_flag_clr;
   assign clr_stb[IDX_P] = p_flag_clr;

   dct_mode_dec u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .mode    (mode),
      .run     (run),
      .en_rise (en_rise)
   );

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      dct_cmp #(.W(CNT_W)) u_cmp (
         .armed   (run),
         .value   (count),
         .ref_val (refs[i]),
         .hit     (hit[i])
      );

      dct_flag u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_ev  (set_ev[i]),
         .clr_stb (clr_stb[i]),
         .flag    (flags[i])
      );
   end

   // A events always flag; P events flag only when P owns the restart
   assign set_ev[IDX_A] = hit[IDX_A];
   assign set_ev[IDX_P] = hit[IDX_P] && !clr_sel;
   assign restart       = clr_sel ? hit[IDX_A] : hit[IDX_P];

   dct_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (restart),
      .count   (count)
   );

   dct_pin u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_rise  (en_rise),
      .init_lvl (init_lvl),
      .a_hit    (hit[IDX_A]),
      .pin_act  (pin_act),
      .pin_out  (pin_out)
   );

   assign a_flag = flags[IDX_A];
   assign p_flag = flags[IDX_P];
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [1:0]       mode,
   input logic [1:0]       pin_act,
   input logic             init_lvl,
   input logic             clr_sel,
   input logic [CNT_W-1:0] ccra,
   input logic [CNT_W-1:0] ccrp,
   input logic             a_flag_clr,
   input logic             p_flag_clr,
   input logic [CNT_W-1:0] count,
   input logic             a_flag,
   input logic             p_flag,
   input logic             pin_out
);
   logic en_q;
   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= enable;
   end

   logic running, a_match, p_match;
   assign running = enable && (mode == 2'b00);
   assign a_match = running && (ccra != '0) && (count == ccra);
   assign p_match = running && (ccrp != '0) && (count == ccrp);

   // R1
   idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> (count == '0));

   // R2
   p_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_match && !clr_sel) |=> (count == '0) && p_flag);

   // R4
   p_flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(p_flag) |-> $past(!clr_sel && p_match));

   // R5
   a_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_flag) |-> $past(a_match));

   // R6
   act_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_match && pin_act == 2'b00 && en_q) |=> $stable(pin_out));

   // R7
   pin_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_out) |-> $past(a_match || (enable && !en_q)));

   // R8
   init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !en_q) |=> (pin_out == $past(init_lvl)));

   // R9
   a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_flag && !a_flag_clr) |=> a_flag);

   // R9
   p_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_flag && !p_flag_clr) |=> p_flag);
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;
   localparam int W = 10;
   localparam int FULL = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [1:0] pin_act = 2'b00;
   logic init_lvl = 1'b0;
   logic clr_sel = 1'b0;
   logic [W-1:0] ccra = '0;
   logic [W-1:0] ccrp = '0;
   logic a_flag_clr = 1'b0;
   logic p_flag_clr = 1'b0;
   logic [W-1:0] count;
   logic a_flag, p_flag, pin_out;

   always #2 clk = ~clk;

   dual_cmp_timer #(.CNT_W(W)) u_dual_cmp_timer (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
      .pin_act(pin_act), .init_lvl(init_lvl), .clr_sel(clr_sel),
      .ccra(ccra), .ccrp(ccrp), .a_flag_clr(a_flag_clr),
      .p_flag_clr(p_flag_clr), .count(count), .a_flag(a_flag),
      .p_flag(p_flag), .pin_out(pin_out)
   );

   typedef struct {
      string req;
      int    kind;
      int    exp;
   } item_t;

   item_t sb_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   // kind: 0 count, 1 a_flag, 2 p_flag, 3 pin_out; checked after the next rising edge
   task automatic expect_item(input string req, input int kind, input int exp);
      item_t it;
      it.req = req; it.kind = kind; it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         while (sb_q.size() > 0) begin
            item_t it;
            int act;
            it = sb_q.pop_front();
            case (it.kind)
               0: act = int'(count);
               1: act = int'(a_flag);
               2: act = int'(p_flag);
               default: act = int'(pin_out);
            endcase
            checks++;
            if (act != it.exp) begin
               errors++;
               $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic clear_flags();
      a_flag_clr = 1'b1; p_flag_clr = 1'b1;
      tick(1);
      a_flag_clr = 1'b0; p_flag_clr = 1'b0;
   endtask

   initial begin : driver
      tick(3);
      rst_n = 1'b1;
      expect_item("reset", 0, 0);
      expect_item("reset", 1, 0);
      expect_item("reset", 2, 0);
      expect_item("reset", 3, 0);
      tick(1);

      // R1: non-compare mode keeps counter at zero, no flags
      mode = 2'b01; ccra = 3; ccrp = 5; enable = 1'b1;
      tick(10);
      expect_item("R1", 0, 0);
      expect_item("R1", 1, 0);
      expect_item("R1", 2, 0);
      tick(1);
      enable = 1'b0; mode = 2'b00;
      tick(2);

      // R2 / R7: P clears, both flags
      ccra = 3; ccrp = 6; clr_sel = 1'b0; pin_act = 2'b10; init_lvl = 1'b0;
      enable = 1'b1;
      expect_item("R2", 0, 1);
      expect_item("R8", 3, 0);
      tick(3);
      expect_item("R2", 0, 4);
      expect_item("R2", 1, 1);
      expect_item("R6", 3, 1);
      expect_item("R2", 2, 0);
      tick(3);
      expect_item("R2", 0, 0);
      expect_item("R2", 2, 1);
      expect_item("R7", 3, 1);
      tick(7);
      expect_item("R2", 0, 0);
      tick(1);
      // R9: clear A strobe (no A event now)
      a_flag_clr = 1'b1;
      expect_item("R9", 1, 0);
      expect_item("R9", 2, 1);
      tick(1);
      a_flag_clr = 1'b0;
      tick(5);
      // count is ccrp now: set wins over clear
      p_flag_clr = 1'b1;
      expect_item("R9", 2, 1);
      expect_item("R2", 0, 0);
      tick(1);
      expect_item("R9", 2, 0);
      tick(1);
      p_flag_clr = 1'b0;

      // R10: drop enable, pin holds
      enable = 1'b0;
      expect_item("R10", 3, 1);
      expect_item("R1", 0, 0);
      tick(4);
      expect_item("R10", 3, 1);
      tick(1);

      // R6 / R8: toggle, high, none, low
      ccra = 2; ccrp = 4; pin_act = 2'b11; init_lvl = 1'b0;
      enable = 1'b1;
      expect_item("R8", 3, 0);
      tick(2);
      expect_item("R6", 3, 1);
      tick(5);
      expect_item("R6", 3, 0);
      tick(1);
      pin_act = 2'b10;
      tick(4);
      expect_item("R6", 3, 1);
      tick(1);
      pin_act = 2'b00;
      tick(4);
      expect_item("R6", 3, 1);
      tick(1);
      pin_act = 2'b01;
      tick(4);
      expect_item("R6", 3, 0);
      tick(1);
      enable = 1'b0;
      tick(1);
      clear_flags();

      // R3: ccrp zero -> full-scale wrap, no P flag
      ccra = 5; ccrp = 0; clr_sel = 1'b0; pin_act = 2'b00;
      enable = 1'b1;
      expect_item("R3", 0, 1);
      tick(FULL - 1);
      expect_item("R3", 0, FULL);
      tick(1);
      expect_item("R3", 0, 0);
      expect_item("R3", 2, 0);
      tick(1);
      enable = 1'b0;
      tick(1);
      clear_flags();

      // R4: A clears, P flag silent though ccrp < ccra
      ccra = 6; ccrp = 2; clr_sel = 1'b1; pin_act = 2'b11; init_lvl = 1'b0;
      enable = 1'b1;
      tick(2);
      expect_item("R4", 2, 0);
      expect_item("R4", 0, 3);
      tick(4);
      expect_item("R4", 0, 0);
      expect_item("R4", 1, 1);
      expect_item("R6", 3, 1);
      expect_item("R4", 2, 0);
      tick(1);
      enable = 1'b0;
      tick(1);
      clear_flags();

      // R5: ccra zero -> wrap at full scale, no A flag, pin unmoved
      ccra = 0; ccrp = 3; clr_sel = 1'b1; pin_act = 2'b11; init_lvl = 1'b1;
      enable = 1'b1;
      expect_item("R8", 3, 1);
      tick(FULL - 1);
      expect_item("R5", 0, FULL);
      tick(1);
      expect_item("R5", 0, 0);
      expect_item("R5", 1, 0);
      expect_item("R5", 3, 1);
      expect_item("R4", 2, 0);
      tick(2);
      enable = 1'b0;
      tick(2);
      done = 1;
   end

   initial begin : watchdog
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule